// File: doc/BRIEF.md
# Serial Flash Status Register Write Controller

This block is the slave-side status register logic of a serial NOR flash, driven over SPI mode 0. It decodes three one-byte instructions: write enable (06h), status write (01h) and status read (05h). It holds the write enable latch and the busy flag. A status write that it accepts starts a self-timed busy cycle, measured in system clocks.

All SPI inputs are brought into the system clock domain and their edges are found there. A status write takes effect only if chip select returns high exactly after the eighth data bit. The write must also have been armed by an earlier write enable, and it must not be blocked by the hardware protect pin. The protect and lock bits change when the busy cycle ends, not when the write is accepted. A reset pulse that arrives while the busy cycle runs is held back until the cycle finishes.

Top module: `spi_status_ctrl`

## Requirements
- R1: A frame carrying opcode 06h whose chip select rises after exactly 8 bits sets the write enable latch (status bit 1), provided no busy cycle runs.
- R2: After opcode 05h the status byte is shifted out on miso MSB first. Miso changes on sck falling edges, and the byte repeats for as long as chip select stays low. The layout is bit 7 lock, bits 6:5 zero, bits 4:2 protect level, bit 1 write enable latch, bit 0 busy. After reset the byte reads 00h.
- R3: Opcode 01h followed by one data byte, with the latch set and chip select rising after exactly 16 bits, starts a busy cycle, and status bit 0 reads 1.
- R4: A status write received while the write enable latch is clear has no effect.
- R5: A status write whose chip select rises after any bit count other than 16 is discarded. The status is unchanged and no busy cycle starts.
- R6: The busy cycle lasts BUSY_CYCLES system clocks. The status can be read during it and shows the old lock and protect bits. At its end, data bit 7 becomes the lock bit, data bits 4:2 become the protect bits, and the write enable latch and busy bit clear.
- R7: Data bits 6, 5, 1 and 0 of a status write have no effect on the status.
- R8: While the lock bit is 1 and wp_n is low, a status write is rejected and leaves the latch set. With wp_n high it is accepted.
- R9: rst_n low while no busy cycle runs clears the write enable latch and aborts any frame. The lock and protect bits are kept.
- R10: A low pulse on rst_n during a busy cycle does not shorten it. The cycle completes with the new values, and the reset is applied afterwards.
- R11: Write enable and status write frames that arrive during a busy cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data in, sampled on sck rising edges |
| miso | output | 1 | Serial data out, updated on sck falling edges |
| wp_n | input | 1 | Hardware write protect, active low |

## Verification
Every SPI input passes through two synchronizer stages and one edge-detect stage. Miso therefore settles about three system clocks after an sck falling edge, and the bench samples it eight clocks after that edge, just before the next rising edge. The busy cycle starts about three clocks after chip select rises. A status read started right after the write therefore shifts out its busy bit well inside BUSY_CYCLES. The bench checks "done" results only after waiting BUSY_CYCLES plus a margin of 100 clocks. Each check reads the status byte through a 05h frame, never at the edge where the value changes.

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl #(
  parameter int unsigned BUSY_CYCLES = 1000,
  parameter logic [7:0]  OP_WEN      = 8'h06,
  parameter logic [7:0]  OP_SWR      = 8'h01,
  parameter logic [7:0]  OP_SRD      = 8'h05
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  input  logic wp_n
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BW-1:0] LAST = BW'(BUSY_CYCLES - 1);

  logic [2:0] cs_s  = 3'b111;
  logic [2:0] sck_s = 3'b000;
  logic [1:0] mo_s  = 2'b00;
  logic [1:0] wp_s  = 2'b11;
  logic [1:0] rs_s  = 2'b00;

  always_ff @(posedge clk) begin
    cs_s  <= {cs_s[1:0], cs_n};
    sck_s <= {sck_s[1:0], sck};
    mo_s  <= {mo_s[0], mosi};
    wp_s  <= {wp_s[0], wp_n};
    rs_s  <= {rs_s[0], rst_n};
  end

  wire sel      = !cs_s[1];
  wire cs_fall  = !cs_s[1] && cs_s[2];
  wire cs_rise  = cs_s[1] && !cs_s[2];
  wire sck_rise = sck_s[1] && !sck_s[2];
  wire sck_fall = !sck_s[1] && sck_s[2];
  wire din      = mo_s[1];
  wire wp_ok    = wp_s[1];
  wire rst_low  = !rs_s[1];

  logic [7:0]    shreg = '0;
  logic [7:0]    op = '0;
  logic [4:0]    cnt = '0;
  logic          rd_mode = 1'b0;
  logic [2:0]    out_idx = '0;
  logic          miso_q = 1'b0;
  logic          wel = 1'b0;
  logic          busy = 1'b0;
  logic [BW-1:0] bcnt = '0;
  logic          lock = 1'b0;
  logic [2:0]    prot = '0;
  logic          n_lock = 1'b0;
  logic [2:0]    n_prot = '0;
  logic          rst_pend = 1'b0;

  wire       rst_mode  = !busy && (rst_low || rst_pend);
  wire       busy_done = busy && (bcnt == LAST);
  wire [7:0] status    = {lock, 2'b00, prot, wel, busy};
  wire [7:0] sh_next   = {shreg[6:0], din};
  wire       wen_ok    = cs_rise && cnt == 5'd8 && op == OP_WEN && !busy && !rst_mode;
  wire       swr_ok    = cs_rise && cnt == 5'd16 && op == OP_SWR && wel && !busy
                         && !rst_mode && !(lock && !wp_ok);

  assign miso = miso_q;

  always_ff @(posedge clk) begin
    if (rst_mode || cs_fall || !sel) begin
      cnt     <= '0;
      rd_mode <= 1'b0;
      out_idx <= '0;
      miso_q  <= 1'b0;
      if (!sel || rst_mode) op <= '0;
    end else begin
      if (sck_rise) begin
        shreg <= sh_next;
        if (cnt != 5'd17) cnt <= cnt + 5'd1;
        if (cnt == 5'd7) begin
          op      <= sh_next;
          rd_mode <= (sh_next == OP_SRD);
        end
      end
      if (sck_fall && rd_mode) begin
        miso_q  <= status[3'd7 - out_idx];
        out_idx <= out_idx + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_mode || busy_done) wel <= 1'b0;
    else if (wen_ok)           wel <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (swr_ok) begin
      busy   <= 1'b1;
      bcnt   <= '0;
      n_lock <= shreg[7];
      n_prot <= shreg[4:2];
    end else if (busy) begin
      if (busy_done) begin
        busy <= 1'b0;
        lock <= n_lock;
        prot <= n_prot;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_low && busy)        rst_pend <= 1'b1;
    else if (!busy && !rst_low) rst_pend <= 1'b0;
  end

  a_r3_busy_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  a_r5_busy_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cnt) == 5'd16 && $past(cs_rise)));
  a_r8_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(lock && !wp_ok));
  a_r6_wel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt != LAST) |=> busy);
  a_r6_bits_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(busy) && !busy) |-> ($stable(prot) && $stable(lock)));
endmodule

// File: tb/spi_status_ctrl_test.sv
`timescale 1ns/1ps
module spi_status_ctrl_test;
  localparam int BUSY = 800;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic wp_n = 1'b1;
  logic miso;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic       m_lock = 1'b0;
  logic [2:0] m_prot = '0;
  logic       m_wel = 1'b0;

  always #2.5 clk = ~clk;

  spi_status_ctrl #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso), .wp_n(wp_n)
  );

  function automatic logic [7:0] model_status(input logic wip);
    return {m_lock, 2'b00, m_prot, m_wel, wip};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] v, input int n);
    cs_n = 1'b0;
    wclk(HALF);
    for (int i = 0; i < n; i++) begin
      mosi = v[15 - (i % 16)];
      wclk(HALF);
      sck = 1'b1;
      wclk(HALF);
      sck = 1'b0;
    end
    wclk(HALF);
    cs_n = 1'b1;
    wclk(4 * HALF);
  endtask

  task automatic rdsr(output logic [7:0] b1, output logic [7:0] b2);
    logic [15:0] r;
    r = '0;
    cs_n = 1'b0;
    wclk(HALF);
    for (int i = 0; i < 8; i++) begin
      mosi = OP_RD[7 - i];
      wclk(HALF);
      sck = 1'b1;
      wclk(HALF);
      sck = 1'b0;
    end
    for (int i = 0; i < 16; i++) begin
      mosi = 1'b0;
      wclk(HALF);
      r[15 - i] = miso;
      sck = 1'b1;
      wclk(HALF);
      sck = 1'b0;
    end
    wclk(HALF);
    cs_n = 1'b1;
    wclk(4 * HALF);
    b1 = r[15:8];
    b2 = r[7:0];
  endtask

  localparam logic [7:0] OP_RD = 8'h05;

  task automatic wren();
    frame({8'h06, 8'h00}, 8);
  endtask

  task automatic pulse_rst();
    rst_n = 1'b0;
    wclk(4);
    rst_n = 1'b1;
    wclk(4);
  endtask

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'd1234));
    wclk(10);
    rst_n = 1'b1;
    wclk(10);

    rdsr(a, b);
    chk("R2 reset value", a, 8'h00);
    chk("R2 repeat byte", b, 8'h00);

    frame({8'h01, 8'h9C}, 16);
    rdsr(a, b);
    chk("R4 write without latch", a, 8'h00);

    wren();
    rdsr(a, b);
    chk("R1 write enable", a, 8'h02);
    chk("R2 repeat with latch", b, 8'h02);

    frame({8'h01, 8'hFF}, 16);
    rdsr(a, b);
    chk("R3 busy visible", a, 8'h03);
    chk("R6 old bits during busy", b, 8'h03);
    wclk(BUSY + 100);
    rdsr(a, b);
    chk("R7 masked data bits", a, 8'h9C);
    m_lock = 1'b1; m_prot = 3'b111; m_wel = 1'b0;

    wp_n = 1'b0;
    wren();
    frame({8'h01, 8'h00}, 16);
    wclk(BUSY + 100);
    rdsr(a, b);
    chk("R8 locked write rejected", a, 8'h9E);
    wp_n = 1'b1;
    frame({8'h01, 8'h00}, 16);
    wclk(BUSY + 100);
    rdsr(a, b);
    chk("R8 wp high allows write", a, 8'h00);

    wren();
    frame({8'h01, 8'h1C}, 15);
    rdsr(a, b);
    chk("R5 short frame", a, 8'h02);
    frame({8'h01, 8'h1C}, 17);
    rdsr(a, b);
    chk("R5 long frame", a, 8'h02);

    frame({8'h01, 8'h1C}, 16);
    wren();
    frame({8'h01, 8'h00}, 16);
    wclk(BUSY + 100);
    rdsr(a, b);
    chk("R11 writes during busy ignored", a, 8'h1C);

    wren();
    pulse_rst();
    rdsr(a, b);
    chk("R9 idle reset clears latch", a, 8'h1C);

    wren();
    frame({8'h01, 8'h08}, 16);
    pulse_rst();
    rdsr(a, b);
    chk("R10 busy survives reset", a, 8'h1F);
    wclk(BUSY + 100);
    rdsr(a, b);
    chk("R10 cycle completes", a, 8'h08);
    m_lock = 1'b0; m_prot = 3'b010; m_wel = 1'b0;

    for (int it = 0; it < 30; it++) begin
      int kind;
      logic [7:0] d;
      int n;
      kind = int'($urandom_range(0, 3));
      d = 8'($urandom);
      wp_n = 1'($urandom);
      if (kind == 0) begin
        wren();
        m_wel = 1'b1;
      end else if (kind == 1) begin
        frame({8'h01, d}, 16);
        if (m_wel && !(m_lock && !wp_n)) begin
          wclk(BUSY + 100);
          m_lock = d[7];
          m_prot = d[4:2];
          m_wel = 1'b0;
        end
      end else if (kind == 2) begin
        n = (d[0]) ? 12 : 17;
        frame({8'h01, d}, n);
      end else begin
        wren();
        m_wel = 1'b1;
        frame({8'h01, d}, 16);
        if (!(m_lock && !wp_n)) begin
          wclk(BUSY + 100);
          m_lock = d[7];
          m_prot = d[4:2];
          m_wel = 1'b0;
        end
      end
      rdsr(a, b);
      chk("R3 R5 R6 R8 random", a, model_status(1'b0));
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule